// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether the destination address of a received frame belongs to a multicast group that the station has subscribed to. The six destination bytes arrive one per cycle, with a marker on the first byte. The block runs a bit-serial-equivalent CRC-32 over them: the CRC starts from all ones, each byte is taken least-significant bit first, and the reflected polynomial 0xEDB88320 is used. The six most significant CRC bits form an index from 0 to 63. That index selects one bit of a 64-bit hash table held in two 32-bit words, and the selected bit decides acceptance.

A group address has bit 0 of its first byte set. Only group addresses are judged by the table. Any other address produces a result marked as not a group address, and that result is never an accept. Loading both table words with all ones admits every group address. Loading both with zero admits none.

Top module: `mcast_hash_filter`

## Requirements
- R1: While `rst_n` is low, `res_valid`, `res_group` and `res_accept` are all low in the cycle after the clock edge.
- R2: The hash index is bits 31:26 of a CRC-32. The CRC is preset to 0xFFFFFFFF and updated over the six address bytes in arrival order, each byte taken least-significant bit first. For each bit, if CRC bit 0 XOR the data bit is 1, the CRC becomes (crc >> 1) XOR 0xEDB88320; otherwise it becomes crc >> 1.
- R3: An index of 32 to 63 selects bit (index − 32) of `table_hi`. An index of 0 to 31 selects bit (index) of `table_lo`. A group address is accepted exactly when the selected bit is 1.
- R4: When bit 0 of the first address byte is 0, the result has `res_group` = 0 and `res_accept` = 0, whatever the table holds.
- R5: With both table words all ones, every group address is accepted. With both table words zero, every group address is rejected.
- R6: `res_valid` is high for exactly one cycle, the cycle after the clock edge that takes the sixth byte. It is never high in two consecutive cycles.
- R7: A byte is taken only when `byte_valid` is high. Idle cycles between the bytes of an address are allowed. A byte marked `byte_first` always restarts the address, dropping any partial one. Bytes without `byte_first` are ignored while no address is in progress.
- R8: The table words are sampled on the clock edge that takes the sixth byte. A table change after that edge does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | An address byte is present on `byte_data` |
| byte_first | input | 1 | The present byte is the first byte of an address |
| byte_data | input | 8 | Address byte, in arrival order |
| table_hi | input | 32 | Hash table bits for indices 32..63 |
| table_lo | input | 32 | Hash table bits for indices 0..31 |
| res_valid | output | 1 | One-cycle strobe: the result fields are valid |
| res_group | output | 1 | The judged address was a group address |
| res_accept | output | 1 | The group address hit a set table bit |

## Verification
The bench loads a one-hot table at each of the 64 positions for several addresses, including broadcast. Exactly one position must accept each address. A wrong preset, bit order or polynomial moves the accepting position, and a swapped register half moves it by 32. Unicast addresses are sent against a full table to catch a filter that ignores the group bit. A restarted partial address and idle gaps between bytes expose a counter that miscounts or keeps stale CRC state. A table change right after the sixth byte exposes a result that is computed a cycle late.

// File: rtl/mhf_pkg.sv
// Package: shared constants of the multicast hash filter.
// Assumes a 32-bit reflected CRC and a 64-entry table in two words.
package mhf_pkg;
    localparam int CRC_W   = 32;
    localparam int BYTE_W  = 8;
    localparam logic [CRC_W-1:0] CRC_POLY   = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_PRESET = 32'hFFFF_FFFF;
endpackage

// File: rtl/mhf_crc_byte.sv
// mhf_crc_byte: combinational update of a reflected CRC by one byte,
// least-significant data bit first. One shift stage per data bit.
// Assumes POLY is given in reflected form.
module mhf_crc_byte #(
    parameter int CRC_W  = 32,
    parameter int BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_in;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        // one reflected shift step for data bit b
        always_comb begin
            if (stage[b][0] ^ data_in[b])
                stage[b+1] = (stage[b] >> 1) ^ POLY;
            else
                stage[b+1] = stage[b] >> 1;
        end
    end

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/mhf_seq.sv
// mhf_seq: tracks the byte position inside an address.
// A byte with 'first' always restarts; other bytes are taken only while
// an address is in progress. 'last' marks the byte that completes it.
// Assumes ADDR_BYTES >= 1.
module mhf_seq #(
    parameter int ADDR_BYTES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_first,
    output logic take,
    output logic restart,
    output logic last
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    // decode which byte is taken and whether it completes the address
    always_comb begin
        restart = in_valid && in_first;
        take    = in_valid && (in_first || active_q);
        if (restart)
            last = (ADDR_BYTES == 1);
        else
            last = take && (cnt_q == LAST_CNT);
    end

    // byte count and in-progress flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (take) begin
            active_q <= !last;
            cnt_q    <= restart ? CNT_W'(1) : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mhf_table_lookup.sv
// mhf_table_lookup: selects one bit of the hash table.
// The upper word holds the upper half of the index range.
// Assumes 2*REG_W == 2**HASH_BITS.
module mhf_table_lookup #(
    parameter int HASH_BITS = 6,
    parameter int REG_W     = 32
) (
    input  logic [HASH_BITS-1:0] index,
    input  logic [REG_W-1:0]     word_hi,
    input  logic [REG_W-1:0]     word_lo,
    output logic                 hit
);
    localparam int TBL_W = 2 * REG_W;

    logic [TBL_W-1:0] table_flat;

    // join the two words with the upper word on top
    always_comb begin
        table_flat = {word_hi, word_lo};
        hit        = table_flat[index];
    end
endmodule

// File: rtl/mcast_hash_filter.sv
// mcast_hash_filter: judges a destination address against a 64-bit
// CRC hash table. Result appears one cycle after the last byte.
// Assumes table words are stable on the edge that takes the last byte.
module mcast_hash_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int REG_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             byte_first,
    input  logic [7:0]       byte_data,
    input  logic [REG_W-1:0] table_hi,
    input  logic [REG_W-1:0] table_lo,
    output logic             res_valid,
    output logic             res_group,
    output logic             res_accept
);
    import mhf_pkg::*;

    localparam int IDX_LSB = CRC_W - HASH_BITS;

    logic                 take, restart, last;
    logic                 group_q, group_now, hit;
    logic [CRC_W-1:0]     crc_q, crc_base, crc_next;
    logic [HASH_BITS-1:0] hash_idx;

    mhf_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (byte_valid),
        .in_first (byte_first),
        .take     (take),
        .restart  (restart),
        .last     (last)
    );

    // a new address starts from the preset, otherwise from the running CRC
    always_comb begin
        crc_base  = restart ? CRC_PRESET : crc_q;
        group_now = restart ? byte_data[0] : group_q;
        hash_idx  = crc_next[CRC_W-1:IDX_LSB];
    end

    mhf_crc_byte #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_base),
        .data_in (byte_data),
        .crc_out (crc_next)
    );

    mhf_table_lookup #(.HASH_BITS(HASH_BITS), .REG_W(REG_W)) u_lookup (
        .index   (hash_idx),
        .word_hi (table_hi),
        .word_lo (table_lo),
        .hit     (hit)
    );

    // running CRC and group flag of the address in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q   <= CRC_PRESET;
            group_q <= 1'b0;
        end else if (take) begin
            crc_q   <= crc_next;
            group_q <= group_now;
        end
    end

    // registered decision, strobed once per completed address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_group  <= 1'b0;
            res_accept <= 1'b0;
        end else begin
            res_valid <= last;
            if (last) begin
                res_group  <= group_now;
                res_accept <= group_now && hit;
            end
        end
    end
endmodule

// File: rtl/mcast_hash_filter_chk.sv
// mcast_hash_filter_chk: protocol properties of the filter's ports.
module mcast_hash_filter_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic [REG_W-1:0] table_hi,
    input logic [REG_W-1:0] table_lo,
    input logic             res_valid,
    input logic             res_group,
    input logic             res_accept
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_group && !res_accept));

    // R4
    non_group_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_group) |-> !res_accept);

    // R5
    full_table_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_group && $past(table_hi) == '1 && $past(table_lo) == '1)
        |-> res_accept);

    // R5
    empty_table_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(table_hi) == '0 && $past(table_lo) == '0)
        |-> !res_accept);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(byte_valid));
endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .table_hi   (table_hi),
    .table_lo   (table_lo),
    .res_valid  (res_valid),
    .res_group  (res_group),
    .res_accept (res_accept)
);

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic        byte_first = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [31:0] table_hi = '0;
    logic [31:0] table_lo = '0;
    logic        res_valid, res_group, res_accept;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mcast_hash_filter u_mcast_hash_filter (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
        .byte_first(byte_first), .byte_data(byte_data),
        .table_hi(table_hi), .table_lo(table_lo),
        .res_valid(res_valid), .res_group(res_group), .res_accept(res_accept)
    );

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d cycles expected<=150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d = a[47-8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ d[k]) c = (c >> 1) ^ 32'hEDB8_8320;
                else             c = c >> 1;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic [47:0] test_addr(input int k);
        logic [47:0] a;
        if (k == 0) return 48'hFFFF_FFFF_FFFF;
        a = 48'h0100_5E00_0001 ^ (48'(k) * 48'h0013_579B_DF2D);
        a[40] = 1'b1;
        return a;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // send one address; optional idle gaps; optional table change after last edge
    task automatic send(input logic [47:0] a, input bit gaps,
                        input bit swap, input logic [31:0] nhi, input logic [31:0] nlo);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i > 0) check("R6 no early result", res_valid, 1'b0);
            byte_valid = 1'b1;
            byte_first = (i == 0);
            byte_data  = a[47-8*i -: 8];
            if (gaps && i < 5) begin
                @(negedge clk);
                byte_valid = 1'b0;
                byte_first = 1'b0;
            end
        end
        @(negedge clk);
        byte_valid = 1'b0;
        byte_first = 1'b0;
        if (swap) begin
            table_hi = nhi;
            table_lo = nlo;
        end
    endtask

    logic [47:0] ad;
    logic [5:0]  hx;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", res_valid, 1'b0);
        check("R1 accept in reset", res_accept, 1'b0);
        check("R1 group in reset", res_group, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3 sweep: one-hot table at every position for several addresses
        for (int k = 0; k < 8; k++) begin
            ad = test_addr(k);
            hx = hash_of(ad);
            for (int b = 0; b < 64; b++) begin
                table_hi = (b >= 32) ? (32'h1 << (b - 32)) : 32'h0;
                table_lo = (b < 32)  ? (32'h1 << b) : 32'h0;
                send(ad, (b % 5) == 0, 1'b0, '0, '0);
                check("R6 result strobe", res_valid, 1'b1);
                check("R2 group flag", res_group, 1'b1);
                if (b >= 32) check("R3 upper word bit", res_accept, hx == 6'(b));
                else         check("R3 lower word bit", res_accept, hx == 6'(b));
                @(negedge clk);
                check("R6 one cycle only", res_valid, 1'b0);
            end
        end

        // R5: full and empty tables
        for (int k = 0; k < 16; k++) begin
            table_hi = '1; table_lo = '1;
            send(test_addr(k), 1'b0, 1'b0, '0, '0);
            check("R5 full table accepts", res_accept, 1'b1);
            table_hi = '0; table_lo = '0;
            send(test_addr(k), 1'b1, 1'b0, '0, '0);
            check("R5 empty table rejects", res_accept, 1'b0);
        end

        // R4: unicast against full table
        for (int k = 0; k < 8; k++) begin
            ad = test_addr(k + 3);
            ad[40] = 1'b0;
            table_hi = '1; table_lo = '1;
            send(ad, 1'b0, 1'b0, '0, '0);
            check("R4 unicast strobe", res_valid, 1'b1);
            check("R4 unicast not group", res_group, 1'b0);
            check("R4 unicast no accept", res_accept, 1'b0);
        end

        // R7: stray bytes while idle produce nothing
        table_hi = '1; table_lo = '1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_first = 1'b0; byte_data = 8'(i * 37 + 1);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check("R7 stray bytes ignored", res_valid, 1'b0);
        end

        // R7: restart inside an address; result must match the second address
        ad = test_addr(5);
        hx = hash_of(ad);
        table_hi = (hx >= 32) ? (32'h1 << (hx - 6'd32)) : 32'h0;
        table_lo = (hx < 32)  ? (32'h1 << hx) : 32'h0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_first = (i == 0); byte_data = 8'hA5 ^ 8'(i);
        end
        send(ad, 1'b0, 1'b0, '0, '0);
        check("R7 restart strobe", res_valid, 1'b1);
        check("R7 restart uses new address", res_accept, 1'b1);

        // R8: table cleared right after the last edge; result keeps old table
        table_hi = '1; table_lo = '1;
        send(test_addr(2), 1'b0, 1'b1, '0, '0);
        check("R8 table sampled at last byte", res_accept, 1'b1);
        table_hi = '0; table_lo = '0;
        send(test_addr(2), 1'b0, 1'b1, '1, '1);
        check("R8 late table set ignored", res_accept, 1'b0);

        // R1: reset mid-address clears progress
        @(negedge clk);
        byte_valid = 1'b1; byte_first = 1'b1; byte_data = 8'h01;
        @(negedge clk);
        rst_n = 1'b0; byte_valid = 1'b0;
        @(negedge clk);
        check("R1 reset clears strobe", res_valid, 1'b0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule